// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the synchronized levels of the pins of one GPIO port and turns qualifying pin activity into sticky per-pin event flags and one port interrupt line. Each pin is first armed for interrupts by its select bit. Two pattern bits then pick the condition that sets its flag. The kind bit picks level or edge. The polarity bit picks high/rising or low/falling. A dual-edge bit turns an edge-mode pin into one that fires on both transitions.

Flags stay set until software writes 1s to the flag-clear address. A per-pin mask bit gates each flag onto the shared interrupt output. A mask bit of 1 blocks the pin. After reset every pin is blocked. Each configuration register has three addresses: one loads the whole word, one ORs in the written 1s and one clears the written 1s. The usual driver sequence clears a pin's flag and then unmasks the pin, so that the line can assert again.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the flags are 0, the interrupt output is 0, and every mask bit is 1, so a flag that sets later does not drive the interrupt output until the pin is unmasked.
- R2: With select=1, kind=0 and polarity=1 (level high), a pin's flag sets on the clock edge where the pin is sampled at 1.
- R3: With select=1, kind=0 and polarity=0 (level low), a pin's flag sets on the clock edge where the pin is sampled at 0.
- R4: With select=1, kind=1, polarity=1 and dual=0 (rising edge), the flag sets only on a 0-to-1 change between successive samples. A pin that stays high sets nothing, and a 1-to-0 change sets nothing.
- R5: With select=1, kind=1, polarity=0 and dual=0 (falling edge), the flag sets only on a 1-to-0 change between successive samples.
- R6: With kind=1 and dual=1, both transitions set the flag, whatever the polarity bit holds.
- R7: A pin whose select bit is 0 never sets its flag.
- R8: Writing to offset 0x58 clears exactly the flags whose data bits are 1. Writes to the flag offset 0x50 change no flag.
- R9: When a clear of a pin's flag and a qualifying event for that pin fall in the same cycle, the flag stays set.
- R10: A level-mode flag cannot be cleared while its level is still active. It is set again on the edge of the clear. Once the level is inactive, the clear takes effect.
- R11: The interrupt output is 1 exactly when some flag is 1 and its mask bit is 0.
- R12: Each configuration register sits at a base offset (select 0x10, mask 0x20, kind 0x30, polarity 0x40, dual 0x70). A write to base loads the word, a write to base+4 sets the written 1s, and a write to base+8 clears the written 1s. Every write takes effect on the clock edge that samples it.
- R13: A set flag stays set when the pin returns to its inactive state, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | NPINS | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | NPINS | Register write data |
| flags | output | NPINS | Latched event flags |
| irq | output | 1 | Port interrupt, OR of unmasked flags |

## Verification
A corrupted configuration bit, or a stale previous-level sample, shows up on the flags output at the first clock edge after the pin moves. A wrong trigger kind or polarity is therefore visible one cycle after the stimulus. A flag that clears on its own, or that ignores a clear, shows up as a wrong flag bit on the edge after the clear write. It also shows up as an interrupt output that disagrees with the mask in that same cycle, because the interrupt output is combinational from the flag and mask registers. Each scenario samples the outputs one cycle after its stimulus, so any such fault surfaces within one clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_SEL      = 8'h10;
    localparam logic [REG_AW-1:0] OFS_MASK     = 8'h20;
    localparam logic [REG_AW-1:0] OFS_KIND     = 8'h30;
    localparam logic [REG_AW-1:0] OFS_POL      = 8'h40;
    localparam logic [REG_AW-1:0] OFS_DUAL     = 8'h70;
    localparam logic [REG_AW-1:0] OFS_FLAG_CLR = 8'h58;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR
    } wr_op_e;

    // {kind, polarity}
    typedef enum logic [1:0] {
        TRIG_LVL_LO   = 2'b00,
        TRIG_LVL_HI   = 2'b01,
        TRIG_EDGE_FALL = 2'b10,
        TRIG_EDGE_RISE = 2'b11
    } trig_e;

    function automatic wr_op_e decode_op(input logic en,
                                         input logic [REG_AW-1:0] addr,
                                         input logic [REG_AW-1:0] base);
        if (!en)                   return OP_NONE;
        if (addr == base)          return OP_LOAD;
        if (addr == base + 8'h04)  return OP_SET;
        if (addr == base + 8'h08)  return OP_CLR;
        return OP_NONE;
    endfunction

    function automatic logic pin_event(input trig_e t, input logic dual,
                                       input logic now, input logic was);
        case (t)
            TRIG_LVL_LO:    return !now;
            TRIG_LVL_HI:    return now;
            TRIG_EDGE_FALL: return dual ? (now != was) : (was && !now);
            TRIG_EDGE_RISE: return dual ? (now != was) : (!was && now);
            default:        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_irq_pkg::*;
#(
    parameter int               W        = 32,
    parameter logic [REG_AW-1:0] BASE    = 8'h10,
    parameter logic             RST_ONES = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      q
);

    wr_op_e op;

    always_comb op = decode_op(wr_en, wr_addr, BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= {W{RST_ONES}};
        end else begin
            case (op)
                OP_LOAD: q <= wr_data;
                OP_SET:  q <= q | wr_data;
                OP_CLR:  q <= q & ~wr_data;
                default: q <= q;
            endcase
        end
    end

    AST_ALIAS_SET: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SET) |=> ((q & $past(wr_data)) == $past(wr_data)));   // R12
    AST_ALIAS_CLR: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR) |=> ((q & $past(wr_data)) == '0));               // R12
    AST_ALIAS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE) |=> $stable(q));                                // R12

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  sel,
    output logic [NPINS-1:0]  mask,
    output logic [NPINS-1:0]  kind,
    output logic [NPINS-1:0]  pol,
    output logic [NPINS-1:0]  dual
);

    localparam int NREGS = 5;
    localparam logic [REG_AW-1:0] BASES [NREGS] =
        '{OFS_SEL, OFS_MASK, OFS_KIND, OFS_POL, OFS_DUAL};
    localparam logic ONES [NREGS] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

    logic [NPINS-1:0] regs_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        gpio_alias_reg #(
            .W        (NPINS),
            .BASE     (BASES[g]),
            .RST_ONES (ONES[g])
        ) u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .q       (regs_q[g])
        );
    end

    assign sel  = regs_q[0];
    assign mask = regs_q[1];
    assign kind = regs_q[2];
    assign pol  = regs_q[3];
    assign dual = regs_q[4];

endmodule

// File: rtl/gpio_event_gen.sv
module gpio_event_gen
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] sel,
    input  logic [NPINS-1:0] kind,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] dual,
    output logic [NPINS-1:0] ev
);

    logic [NPINS-1:0] prev_q;

    // Reload during reset too, so a pin held high through reset is no edge.
    always_ff @(posedge clk) prev_q <= pin_lvl;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        trig_e trig;
        always_comb begin
            trig  = trig_e'({kind[p], pol[p]});
            ev[p] = sel[p] && pin_event(trig, dual[p], pin_lvl[p], prev_q[p]);
        end
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        ((ev & kind & ~(pin_lvl ^ prev_q)) == '0));                     // R4

endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  ev,
    input  logic [NPINS-1:0]  mask,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  flags,
    output logic              irq
);

    logic [NPINS-1:0] clr;

    always_comb clr = (wr_en && wr_addr == OFS_FLAG_CLR) ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | ev;
    end

    always_comb irq = |(flags & ~mask);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));   // R13
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(ev)) == $past(ev)));                       // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(clr & ~ev)) == '0));                       // R8

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_lvl,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  flags,
    output logic              irq
);

    logic [NPINS-1:0] sel, mask, kind, pol, dual, ev;

    gpio_cfg_bank #(.NPINS(NPINS)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel     (sel),
        .mask    (mask),
        .kind    (kind),
        .pol     (pol),
        .dual    (dual)
    );

    gpio_event_gen #(.NPINS(NPINS)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .pin_lvl (pin_lvl),
        .sel     (sel),
        .kind    (kind),
        .pol     (pol),
        .dual    (dual),
        .ev      (ev)
    );

    gpio_flag_bank #(.NPINS(NPINS)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .mask    (mask),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .flags   (flags),
        .irq     (irq)
    );

    AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(~sel & ~flags)) == '0));               // R7
    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> !irq);                                         // R11

endmodule

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
    import gpio_irq_pkg::*;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pin_lvl = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [N-1:0]  wr_data = '0;
    logic [N-1:0]  flags;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_irq_detect #(.NPINS(N)) u0 (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .flags(flags), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pin(input int i, input logic v);
        @(negedge clk);
        pin_lvl[i] = v;
        @(negedge clk);
    endtask

    task automatic arm(input int i, input logic k, input logic p);
        wr(k ? 8'h34 : 8'h38, N'(1) << i);
        wr(p ? 8'h44 : 8'h48, N'(1) << i);
        wr(8'h14, N'(1) << i);
    endtask

    task automatic disarm(input int i);
        wr(8'h18, N'(1) << i);
        wr(8'h58, N'(1) << i);
    endtask

    task automatic t_reset;
        chk("R1 flags", flags, '0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_level_high;
        arm(0, 0, 1);
        chk("R2 idle", 32'(flags[0]), 0);
        pin(0, 1);
        chk("R2 set", 32'(flags[0]), 1);
        wr(8'h58, 32'h1);
        chk("R10 clear while active", 32'(flags[0]), 1);
        pin(0, 0);
        chk("R13 sticky", 32'(flags[0]), 1);
        wr(8'h58, 32'h1);
        chk("R10 clear when inactive", 32'(flags[0]), 0);
        disarm(0);
    endtask

    task automatic t_level_low;
        pin(1, 1);
        arm(1, 0, 0);
        chk("R3 idle", 32'(flags[1]), 0);
        pin(1, 0);
        chk("R3 set", 32'(flags[1]), 1);
        pin(1, 1);
        wr(8'h58, 32'h2);
        chk("R3 cleared", 32'(flags[1]), 0);
        disarm(1);
    endtask

    task automatic t_rise;
        arm(2, 1, 1);
        pin(2, 1);
        chk("R4 rise", 32'(flags[2]), 1);
        wr(8'h58, 32'h4);
        chk("R4 held high no set", 32'(flags[2]), 0);
        pin(2, 0);
        chk("R4 fall ignored", 32'(flags[2]), 0);
        disarm(2);
    endtask

    task automatic t_fall;
        arm(3, 1, 0);
        pin(3, 1);
        chk("R5 rise ignored", 32'(flags[3]), 0);
        pin(3, 0);
        chk("R5 fall", 32'(flags[3]), 1);
        disarm(3);
    endtask

    task automatic t_dual;
        arm(4, 1, 1);
        wr(8'h74, 32'h10);
        pin(4, 1);
        chk("R6 rise", 32'(flags[4]), 1);
        wr(8'h58, 32'h10);
        chk("R6 cleared", 32'(flags[4]), 0);
        pin(4, 0);
        chk("R6 fall", 32'(flags[4]), 1);
        wr(8'h78, 32'h10);
        disarm(4);
    endtask

    task automatic t_unselected;
        wr(8'h44, 32'h20);
        pin(5, 1);
        chk("R7 never selected", 32'(flags[5]), 0);
        pin(5, 0);
        arm(0, 0, 1);
        wr(8'h18, 32'h1);
        pin(0, 1);
        chk("R7 deselected", 32'(flags[0]), 0);
        pin(0, 0);
    endtask

    task automatic t_w1c;
        arm(6, 1, 1);
        arm(7, 1, 1);
        @(negedge clk); pin_lvl[6] = 1; pin_lvl[7] = 1;
        @(negedge clk);
        chk("R8 both set", flags & 32'hC0, 32'hC0);
        wr(8'h50, '1);
        chk("R8 read-only offset", flags & 32'hC0, 32'hC0);
        wr(8'h58, 32'h40);
        chk("R8 selective clear", flags & 32'hC0, 32'h80);
    endtask

    task automatic t_coincide;
        arm(8, 1, 1);
        @(negedge clk);
        pin_lvl[8] = 1; wr_en = 1; wr_addr = 8'h58; wr_data = 32'h100;
        @(negedge clk);
        wr_en = 0;
        chk("R9 event beats clear", 32'(flags[8]), 1);
        wr(8'h58, 32'h100);
    endtask

    task automatic t_irq;
        // flag 7 still set from t_w1c, mask still all ones
        chk("R1 masked after reset", 32'(irq), 0);
        wr(8'h28, 32'h80);
        chk("R11 unmasked", 32'(irq), 1);
        wr(8'h24, 32'h80);
        chk("R12 set alias masks", 32'(irq), 0);
        wr(8'h20, ~32'h80);
        chk("R12 load", 32'(irq), 1);
        wr(8'h58, 32'h80);
        chk("R11 no flag", 32'(irq), 0);
        wr(8'h20, '1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_level_high();
        t_level_low();
        t_rise();
        t_fall();
        t_dual();
        t_unselected();
        t_w1c();
        t_coincide();
        t_irq();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule